// File: doc/BRIEF.md
# String Copy Address Sequencer

This block produces the address pairs for a block string copy. The control side sets up several inputs and then pulses a start strobe. These inputs are a source offset, a destination offset, a repeat count, two segment bases, a direction bit and an element-size bit. The block then offers one transfer at a time on a valid/ready handshake. Each transfer carries a 20-bit source physical address and a 20-bit destination physical address. The source address is formed from the source segment base and the source index. The destination address is formed from the destination segment base and the destination index. In both cases the physical address is the segment value shifted left by four bits plus the 16-bit offset.

Each accepted handshake moves both indices by the element size. The indices go up when the direction bit is clear and down when it is set. The count drops by one on each handshake. After the last accepted transfer the block drops valid and pulses done for one cycle. The memory data path sits downstream and is out of scope.

Top module: `strmov_addr_seq`

## Requirements
- R1: After reset, `xfer_valid`, `done` and `busy` are all low.
- R2: One cycle after an accepted start with a nonzero count, `xfer_valid` is high. `src_addr` then equals (`cfg_src_seg` << 4) + `cfg_src_ofs` modulo 2^20, and `dst_addr` equals (`cfg_dst_seg` << 4) + `cfg_dst_ofs` modulo 2^20. `busy` stays high until `done` has pulsed.
- R3: With `cfg_down` = 0 latched, each accepted handshake (`xfer_valid` && `xfer_ready`) raises both indices by the step size. The new addresses appear in the following cycle.
- R4: With `cfg_down` = 1 latched, each accepted handshake lowers both indices by the step size.
- R5: The step size is 1 when `cfg_word` = 0 and 2 when `cfg_word` = 1. The direction and size are latched at start, and later changes to the configuration inputs have no effect on the run.
- R6: Each index wraps modulo 2^16 and never carries into the segment part. The physical address sum itself wraps modulo 2^20.
- R7: Exactly `cfg_count` handshakes are offered. In the cycle after the last one, `xfer_valid` is low and `done` is high for exactly one cycle.
- R8: A start with `cfg_count` = 0 offers no transfer, and `done` is high in the cycle after the start.
- R9: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `src_addr` and `dst_addr` hold their values.
- R10: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the configuration inputs (honoured only when idle) |
| cfg_src_seg | input | 16 | Source segment base |
| cfg_dst_seg | input | 16 | Destination segment base |
| cfg_src_ofs | input | 16 | Initial source index |
| cfg_dst_ofs | input | 16 | Initial destination index |
| cfg_count | input | 16 | Number of elements to transfer |
| cfg_down | input | 1 | 0: indices increase, 1: indices decrease |
| cfg_word | input | 1 | 0: step 1, 1: step 2 |
| xfer_ready | input | 1 | Downstream accepts the current address pair |
| xfer_valid | output | 1 | Address pair is offered |
| src_addr | output | 20 | Source physical address |
| dst_addr | output | 20 | Destination physical address |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong index shows up at the address ports in the cycle after the handshake that produced it. The bench therefore compares both addresses against its own model on every cycle in which valid is high, including stalled cycles. A wrong count shows up as a valid that stays high or drops early against the bench's handshake tally. A wrong end-of-run flag shows up as a done pulse that is missing, early or stretched, and the bench sees it one cycle after the last handshake. A wrongly latched direction or size corrupts the very next address, so the mid-run configuration changes and ignored start pulses surface on the following beat.

// File: rtl/strseq_pkg.sv
package strseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  localparam int unsigned NUM_PTRS = 2;
  localparam int unsigned PTR_SRC  = 0;
  localparam int unsigned PTR_DST  = 1;
endpackage

// File: rtl/idx_stepper.sv
module idx_stepper #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [OFS_W-1:0]            seg_in,
  input  logic [OFS_W-1:0]            ofs_in,
  input  logic                        adv,
  input  logic                        down,
  input  logic                        wide,
  output logic [OFS_W+SEG_SHIFT-1:0]  addr_o
);
  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0] seg_q, idx_q, idx_nxt, step_w;
  logic [PA_W-1:0]  addr_q;

  assign step_w  = wide ? OFS_W'(2) : OFS_W'(1);
  assign idx_nxt = down ? (idx_q - step_w) : (idx_q + step_w);

  function automatic logic [PA_W-1:0] phys(input logic [OFS_W-1:0] s,
                                           input logic [OFS_W-1:0] o);
    return {s, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, o};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (load) begin
      seg_q  <= seg_in;
      idx_q  <= ofs_in;
      addr_q <= phys(seg_in, ofs_in);
    end else if (adv) begin
      idx_q  <= idx_nxt;
      addr_q <= phys(seg_q, idx_nxt);
    end
  end

  assign addr_o = addr_q;

  assert_index_up_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !down) |=> idx_q == OFS_W'($past(idx_q) + $past(step_w)));

  assert_index_down_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && down) |=> idx_q == OFS_W'($past(idx_q) - $past(step_w)));

  assert_seg_held_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(seg_q));
endmodule

// File: rtl/rep_counter.sv
module rep_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
  assign zero_o = (cnt_q == '0);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    dec |-> cnt_q != '0);

  assert_count_dec_R7: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/strmov_addr_seq.sv
module strmov_addr_seq
  import strseq_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [OFS_W-1:0]           cfg_src_seg,
  input  logic [OFS_W-1:0]           cfg_dst_seg,
  input  logic [OFS_W-1:0]           cfg_src_ofs,
  input  logic [OFS_W-1:0]           cfg_dst_ofs,
  input  logic [CNT_W-1:0]           cfg_count,
  input  logic                       cfg_down,
  input  logic                       cfg_word,
  input  logic                       xfer_ready,
  output logic                       xfer_valid,
  output logic [OFS_W+SEG_SHIFT-1:0] src_addr,
  output logic [OFS_W+SEG_SHIFT-1:0] dst_addr,
  output logic                       busy,
  output logic                       done
);
  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  seq_state_t state_q;
  logic valid_q, done_q, down_q, wide_q;
  logic accept, fire, cnt_last, cnt_zero;
  logic [OFS_W-1:0] seg_sel [NUM_PTRS];
  logic [OFS_W-1:0] ofs_sel [NUM_PTRS];
  logic [PA_W-1:0]  addr_sel [NUM_PTRS];

  assign accept = start && (state_q == ST_IDLE);
  assign fire   = valid_q && xfer_ready;

  assign seg_sel[PTR_SRC] = cfg_src_seg;
  assign seg_sel[PTR_DST] = cfg_dst_seg;
  assign ofs_sel[PTR_SRC] = cfg_src_ofs;
  assign ofs_sel[PTR_DST] = cfg_dst_ofs;

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    idx_stepper #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_step (
      .clk    (clk),
      .rst    (rst),
      .load   (accept),
      .seg_in (seg_sel[g]),
      .ofs_in (ofs_sel[g]),
      .adv    (fire),
      .down   (down_q),
      .wide   (wide_q),
      .addr_o (addr_sel[g])
    );
  end

  rep_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cfg_count),
    .dec      (fire),
    .last_o   (cnt_last),
    .zero_o   (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      down_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          down_q <= cfg_down;
          wide_q <= cfg_word;
          if (cfg_count == '0) begin
            state_q <= ST_FIN;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            valid_q <= 1'b1;
          end
        end
        ST_RUN: if (fire && cnt_last) begin
          state_q <= ST_FIN;
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_valid = valid_q;
  assign done       = done_q;
  assign busy       = (state_q != ST_IDLE);
  assign src_addr   = addr_sel[PTR_SRC];
  assign dst_addr   = addr_sel[PTR_DST];

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> xfer_valid && $stable(src_addr) && $stable(dst_addr));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !xfer_valid);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_count == '0) |=> done && !xfer_valid);

  assert_mode_latched_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != ST_FIN) |=> $stable(down_q) && $stable(wide_q));

  assert_run_live_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (xfer_valid && !cnt_zero));
endmodule

// File: tb/tb_strmov_addr_seq.sv
`timescale 1ns/1ps
module tb_strmov_addr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] cfg_src_seg, cfg_dst_seg, cfg_src_ofs, cfg_dst_ofs, cfg_count;
  logic        cfg_down, cfg_word, xfer_ready;
  logic        xfer_valid, busy, done;
  logic [19:0] src_addr, dst_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  strmov_addr_seq dut (
    .clk(clk), .rst(rst), .start(start),
    .cfg_src_seg(cfg_src_seg), .cfg_dst_seg(cfg_dst_seg),
    .cfg_src_ofs(cfg_src_ofs), .cfg_dst_ofs(cfg_dst_ofs),
    .cfg_count(cfg_count), .cfg_down(cfg_down), .cfg_word(cfg_word),
    .xfer_ready(xfer_ready), .xfer_valid(xfer_valid),
    .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] ssg, input logic [15:0] dsg,
                         input logic [15:0] so, input logic [15:0] dof,
                         input logic [15:0] cnt, input bit dn, input bit wd,
                         input string tag, input bit poke);
    logic [15:0] ms, md, stp;
    int beats;
    bit rdy;
    @(negedge clk);
    cfg_src_seg = ssg; cfg_dst_seg = dsg; cfg_src_ofs = so; cfg_dst_ofs = dof;
    cfg_count = cnt; cfg_down = dn; cfg_word = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ms = so; md = dof; stp = wd ? 16'd2 : 16'd1; beats = 0;
    if (cnt == 16'd0) begin
      chk(done && !xfer_valid, "R8", "zero-count done/valid", {30'd0, done, xfer_valid}, 32'h2);
      @(negedge clk);
      chk(!done, "R7", "done width", {31'd0, done}, 32'd0);
      return;
    end
    chk(busy, "R2", "busy in run", {31'd0, busy}, 32'd1);
    for (int it = 0; it < 4000; it++) begin
      chk(xfer_valid, tag, "valid during run", {31'd0, xfer_valid}, 32'd1);
      chk(src_addr == phys(ssg, ms), tag, "src_addr", {12'd0, src_addr}, {12'd0, phys(ssg, ms)});
      chk(dst_addr == phys(dsg, md), tag, "dst_addr", {12'd0, dst_addr}, {12'd0, phys(dsg, md)});
      rdy = ($urandom % 3) != 0;
      xfer_ready = rdy;
      if (poke && ($urandom % 4) == 0) begin
        cfg_src_seg = 16'($urandom); cfg_dst_seg = 16'($urandom);
        cfg_src_ofs = 16'($urandom); cfg_dst_ofs = 16'($urandom);
        cfg_count = 16'($urandom); cfg_down = ~dn; cfg_word = ~wd;
        start = 1'b1;  // R10: must be ignored, R5: mode stays latched
      end
      @(negedge clk);
      start = 1'b0;
      xfer_ready = 1'b0;
      if (rdy) begin
        beats++;
        ms = dn ? ms - stp : ms + stp;
        md = dn ? md - stp : md + stp;
        if (beats == int'(cnt)) begin
          chk(done && !xfer_valid, "R7", "end of run done/valid",
              {30'd0, done, xfer_valid}, 32'h2);
          @(negedge clk);
          chk(!done && !busy, "R7", "done width / idle", {30'd0, done, busy}, 32'd0);
          return;
        end
      end
    end
    chk(1'b0, "R7", "run did not end", 32'd0, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; xfer_ready = 1'b0;
    cfg_src_seg = '0; cfg_dst_seg = '0; cfg_src_ofs = '0; cfg_dst_ofs = '0;
    cfg_count = '0; cfg_down = 1'b0; cfg_word = 1'b0;
    repeat (3) @(negedge clk);
    chk(!xfer_valid && !done && !busy, "R1", "reset outputs",
        {29'd0, xfer_valid, done, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R2/R3 byte upward
    run_one(16'h1000, 16'h2000, 16'h0010, 16'h0100, 16'd5, 1'b0, 1'b0, "R3", 1'b0);
    // R4/R5 word downward
    run_one(16'h3000, 16'h4000, 16'h0200, 16'h0400, 16'd6, 1'b1, 1'b1, "R4", 1'b0);
    // R5 word upward
    run_one(16'h0001, 16'h0002, 16'h0000, 16'h0000, 16'd4, 1'b0, 1'b1, "R5", 1'b0);
    // R6 wrap upward, word step past 0xFFFF
    run_one(16'h0100, 16'h0200, 16'hFFFF, 16'hFFFE, 16'd3, 1'b0, 1'b1, "R6", 1'b0);
    // R6 wrap downward past zero
    run_one(16'h0100, 16'h0200, 16'h0001, 16'h0000, 16'd3, 1'b1, 1'b1, "R6", 1'b0);
    // R6 physical sum above 2^20
    run_one(16'hFFFF, 16'hFFF0, 16'hFFFF, 16'hFFF0, 16'd2, 1'b0, 1'b0, "R6", 1'b0);
    // R7 single element, R8 zero count
    run_one(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'd1, 1'b0, 1'b0, "R7", 1'b0);
    run_one(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'd0, 1'b0, 1'b0, "R8", 1'b0);
    // random runs with stalls (R9) and ignored restarts (R10)
    for (int r = 0; r < 30; r++) begin
      logic dn_r;
      dn_r = 1'($urandom);
      run_one(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
              16'($urandom % 20), dn_r, 1'($urandom), dn_r ? "R4" : "R3", 1'b1);
    end
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule